// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator with Selectable Resolution

This block drives four pulse-width-modulated outputs from one base clock. Each channel first divides the clock by a programmable 16-bit value plus one. The divided ticks then advance a period counter. That counter wraps after 255 ticks in the coarse mode and after 4095 ticks in the fine mode. The output is high while the period counter is below the channel's width value. The coarse mode gives a faster PWM frequency; the fine mode gives finer duty steps.

Software reaches the channel settings through a small register window. An index register picks one channel. Three further registers then read or write that channel's mode, divider and width. New settings go into a pending copy. A channel takes them on only when its running period ends, so a period is never cut short or stretched by a write. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output is low and every register reads zero (index, and each channel's mode, divider and width).
- R2: Register address 0 holds a 4-bit channel index in D3..D0. Addresses 1 (mode, D0), 2 (divider, D15..D0) and 3 (width, D11..D0) read and write the channel the index names, and a read returns the last value written to that channel.
- R3: While the index is 4 to 15, writes to addresses 1..3 change no channel, and reads of addresses 1..3 return zero.
- R4: Mode 0 gives a period of 255 divided ticks, and mode 1 gives a period of 4095 divided ticks.
- R5: A divider value P makes each divided tick last P+1 clock cycles, so one period lasts (P+1)*255 or (P+1)*4095 clocks.
- R6: A period starts with the output high for (P+1)*W clocks, where W is the effective width; the output stays low for the rest of the period.
- R7: In mode 0 only width bits D7..D0 take effect; bits D11..D8 are kept for readback but do not change the output.
- R8: A width of 0 keeps the output low all the time. A width equal to the full period (255 in mode 0, 4095 in mode 1) keeps it high all the time.
- R9: A change of mode, divider or width takes effect only at the start of the next period of that channel; the current period completes with the old settings.
- R10: The four channels run independently, each from its own settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| reg_wr | input | 1 | Write strobe for the register window |
| reg_addr | input | 2 | Register select: 0 index, 1 mode, 2 divider, 3 width |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, valid in the same cycle |
| pwm_out | output | 4 | PWM output per channel, bit n for channel n |

## Verification
A register write lands on the clock edge that samples the strobe, and the readback is combinational, so the bench reads back one cycle after each write. The outputs follow the new settings only from the first period start after the write. For that reason every duty and period measurement first waits for the output to go low and then for a rising edge. A rising edge can only mark a period start. The high and low runs are then counted in clocks sampled on the falling edge and compared against (P+1)*W and (P+1)*period. Settings that produce no edge at all, such as zero and full width, are checked by holding a window open for longer than two old periods and then requiring a constant level.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  typedef enum logic [1:0] {
    ADDR_INDEX    = 2'd0,
    ADDR_MODE     = 2'd1,
    ADDR_PRESCALE = 2'd2,
    ADDR_WIDTH    = 2'd3
  } pwm_addr_e;

  localparam int unsigned PWM_NUM_CH = 4;
  localparam int unsigned PWM_IDX_W  = 4;
  localparam int unsigned PWM_PRE_W  = 16;
  localparam int unsigned PWM_WID_W  = 12;
  localparam int unsigned PWM_LO_W   = 8;
  localparam int unsigned PWM_DATA_W = 16;

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = PWM_NUM_CH,
  parameter int unsigned IDX_W  = PWM_IDX_W,
  parameter int unsigned PRE_W  = PWM_PRE_W,
  parameter int unsigned WID_W  = PWM_WID_W,
  parameter int unsigned DATA_W = PWM_DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [1:0]              reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  output logic [NUM_CH-1:0]       pend_mode,
  output logic [NUM_CH*PRE_W-1:0] pend_pre,
  output logic [NUM_CH*WID_W-1:0] pend_width
);

  localparam logic [IDX_W:0] NUM_CH_L = (IDX_W+1)'(NUM_CH);

  pwm_addr_e      addr;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             idx_valid;

  assign addr      = pwm_addr_e'(reg_addr);
  assign idx_valid = ({1'b0, idx_q} < NUM_CH_L);

  always_comb begin
    idx_en = reg_wr && (addr == ADDR_INDEX);
    idx_d  = reg_wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             hit;
    logic             mode_q, mode_d, mode_en;
    logic [PRE_W-1:0] pre_q, pre_d;
    logic             pre_en;
    logic [WID_W-1:0] wid_q, wid_d;
    logic             wid_en;

    assign hit = reg_wr && (idx_q == IDX_W'(c));

    always_comb begin
      mode_en = hit && (addr == ADDR_MODE);
      pre_en  = hit && (addr == ADDR_PRESCALE);
      wid_en  = hit && (addr == ADDR_WIDTH);
      mode_d  = reg_wdata[0];
      pre_d   = reg_wdata[PRE_W-1:0];
      wid_d   = reg_wdata[WID_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q <= 1'b0;
        pre_q  <= '0;
        wid_q  <= '0;
      end else begin
        if (mode_en) mode_q <= mode_d;
        if (pre_en)  pre_q  <= pre_d;
        if (wid_en)  wid_q  <= wid_d;
      end
    end

    assign pend_mode[c]                  = mode_q;
    assign pend_pre[c*PRE_W +: PRE_W]    = pre_q;
    assign pend_width[c*WID_W +: WID_W]  = wid_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (addr == ADDR_INDEX) begin
      reg_rdata = DATA_W'(idx_q);
    end else if (idx_valid) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (idx_q == IDX_W'(c)) begin
          case (addr)
            ADDR_MODE:     reg_rdata = DATA_W'(pend_mode[c]);
            ADDR_PRESCALE: reg_rdata = DATA_W'(pend_pre[c*PRE_W +: PRE_W]);
            ADDR_WIDTH:    reg_rdata = DATA_W'(pend_width[c*WID_W +: WID_W]);
            default:       reg_rdata = '0;
          endcase
        end
      end
    end
  end

  // R3
  oor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !idx_valid && (addr != ADDR_INDEX))
      |=> ($stable(pend_mode) && $stable(pend_pre) && $stable(pend_width)));

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && (addr == ADDR_INDEX)) |=> $stable(idx_q));

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);

  logic [PRE_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == div);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div);

  // R5
  pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (cnt_q == $past(cnt_q) + PRE_W'(1)));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int unsigned PRE_W = 16,
  parameter int unsigned WID_W = 12,
  parameter int unsigned LO_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_mode,
  input  logic [PRE_W-1:0] pend_pre,
  input  logic [WID_W-1:0] pend_width,
  output logic             pwm
);

  localparam logic [WID_W-1:0] LAST_HI = {{(WID_W-1){1'b1}}, 1'b0};
  localparam logic [WID_W-1:0] LAST_LO = WID_W'((1 << LO_W) - 2);

  logic             act_mode_q;
  logic [PRE_W-1:0] act_pre_q;
  logic [WID_W-1:0] act_wid_q;
  logic             act_en;
  logic [WID_W-1:0] per_q, per_d;
  logic             per_en;
  logic             tick;
  logic             boundary;
  logic [WID_W-1:0] last_val;
  logic [WID_W-1:0] width_eff;

  pwm_prescaler #(.PRE_W(PRE_W)) i_div (
    .clk  (clk),
    .rst_n(rst_n),
    .div  (act_pre_q),
    .tick (tick)
  );

  always_comb begin
    last_val  = act_mode_q ? LAST_HI : LAST_LO;
    width_eff = act_mode_q ? act_wid_q
                           : {{(WID_W-LO_W){1'b0}}, act_wid_q[LO_W-1:0]};
    boundary  = tick && (per_q == last_val);
    per_en    = tick;
    per_d     = boundary ? '0 : per_q + WID_W'(1);
    act_en    = boundary;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      per_q <= '0;
    else if (per_en) per_q <= per_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode_q <= 1'b0;
      act_pre_q  <= '0;
      act_wid_q  <= '0;
    end else if (act_en) begin
      act_mode_q <= pend_mode;
      act_pre_q  <= pend_pre;
      act_wid_q  <= pend_width;
    end
  end

  assign pwm = (per_q < width_eff);

  // R4
  per_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_q <= last_val);

  // R6
  per_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !boundary) |=> (per_q == $past(per_q) + WID_W'(1)));

  // R9
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(act_mode_q) && $stable(act_pre_q) && $stable(act_wid_q)));

  // R8
  zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (width_eff == '0) |-> !pwm);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = PWM_NUM_CH,
  parameter int unsigned IDX_W  = PWM_IDX_W,
  parameter int unsigned PRE_W  = PWM_PRE_W,
  parameter int unsigned WID_W  = PWM_WID_W,
  parameter int unsigned LO_W   = PWM_LO_W,
  parameter int unsigned DATA_W = PWM_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  logic                    rst_sync_n;
  logic [NUM_CH-1:0]       pend_mode;
  logic [NUM_CH*PRE_W-1:0] pend_pre;
  logic [NUM_CH*WID_W-1:0] pend_width;

  pwm_rst_sync #(.STAGES(2)) i_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  pwm_regfile #(
    .NUM_CH(NUM_CH), .IDX_W(IDX_W), .PRE_W(PRE_W),
    .WID_W (WID_W),  .DATA_W(DATA_W)
  ) i_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pend_mode (pend_mode),
    .pend_pre  (pend_pre),
    .pend_width(pend_width)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pwm
    pwm_channel #(.PRE_W(PRE_W), .WID_W(WID_W), .LO_W(LO_W)) i_ch (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .pend_mode (pend_mode[c]),
      .pend_pre  (pend_pre[c*PRE_W +: PRE_W]),
      .pend_width(pend_width[c*WID_W +: WID_W]),
      .pwm       (pwm_out[c])
    );
  end

endmodule

// File: tb/test_pwm_bank.sv
`timescale 1ns/1ps
module test_pwm_bank;

  localparam int TMO = 30000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic [3:0]  pwm_out;

  int tests = 0;
  int failed = 0;

  always #2.5 clk = ~clk;

  pwm_bank i_pwm_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = 2'(a);
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic cfg(input int ch, input int mode, input int pre, input int wid);
    wr(0, ch); wr(1, mode); wr(2, pre); wr(3, wid);
  endtask

  task automatic measure(input int ch, output int hi, output int per);
    int n;
    n = 0; hi = 0; per = 0;
    @(negedge clk);
    while (pwm_out[ch] && n < TMO) begin @(negedge clk); n++; end
    while (!pwm_out[ch] && n < TMO) begin @(negedge clk); n++; end
    while (pwm_out[ch] && n < TMO) begin hi++; @(negedge clk); n++; end
    per = hi;
    while (!pwm_out[ch] && n < TMO) begin per++; @(negedge clk); n++; end
    if (n >= TMO) begin hi = -1; per = -1; end
  endtask

  task automatic meas_check(input int ch, input int ehi, input int eper, input string tag);
    int hi, per;
    measure(ch, hi, per);
    check(hi == ehi, {tag, " high time"}, hi, ehi);
    check(per == eper, {tag, " period"}, per, eper);
  endtask

  task automatic hold_check(input int ch, input bit lvl, input int cyc, input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (pwm_out[ch] != lvl) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; failed++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    int v, hi, n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    check(pwm_out == 4'd0, "R1 outputs low", int'(pwm_out), 0);
    rd(0, v); check(v == 0, "R1 index", v, 0);
    for (int c = 0; c < 4; c++) begin
      wr(0, c);
      for (int a = 1; a < 4; a++) begin
        rd(a, v); check(v == 0, "R1 channel register", v, 0);
      end
    end
    wr(0, 0);
    hold_check(0, 1'b0, 300, "R1 R8 zero width stays low");

    // R2 R7: configure and read back
    cfg(0, 0, 0, 100);
    cfg(1, 1, 0, 2047);
    cfg(2, 0, 0, 200);
    cfg(3, 0, 2, 16'h140);
    wr(0, 3);
    rd(0, v); check(v == 3, "R2 index readback", v, 3);
    rd(2, v); check(v == 2, "R2 divider readback", v, 2);
    rd(3, v); check(v == 16'h140, "R7 full width kept for readback", v, 16'h140);
    wr(0, 1);
    rd(1, v); check(v == 1, "R2 mode readback", v, 1);
    rd(3, v); check(v == 2047, "R2 width readback", v, 2047);
    wr(2, 16'hFFFF); rd(2, v); check(v == 16'hFFFF, "R2 divider full range", v, 16'hFFFF);
    wr(2, 0);

    // R10 R6 R4 R7 R5: all channels running at once
    meas_check(0, 100, 255, "R10 R6 ch0");
    meas_check(1, 2047, 4095, "R4 ch1 fine half duty");
    meas_check(2, 200, 255, "R10 ch2");
    meas_check(3, 3 * 64, 3 * 255, "R7 R5 ch3 upper width bits ignored");

    // R5 R6: sweep divider and width in coarse mode
    for (int p = 0; p < 4; p++) begin
      int ws[3] = '{1, 128, 254};
      for (int k = 0; k < 3; k++) begin
        cfg(0, 0, p, ws[k]);
        meas_check(0, (p + 1) * ws[k], (p + 1) * 255, "R5 R6 sweep");
      end
    end

    // R4 R5: fine mode with divider
    cfg(1, 1, 1, 1);
    meas_check(1, 2, 2 * 4095, "R4 R5 fine divided");
    cfg(1, 1, 0, 4000);
    meas_check(1, 4000, 4095, "R4 fine wide");

    // R9: change width in the middle of a high phase
    wr(0, 2);
    n = 0;
    @(negedge clk);
    while (pwm_out[2] && n < TMO) begin @(negedge clk); n++; end
    while (!pwm_out[2] && n < TMO) begin @(negedge clk); n++; end
    hi = 0;
    while (pwm_out[2] && n < TMO) begin
      if (hi == 50) begin reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 16'd10; end
      else reg_wr = 1'b0;
      hi++; @(negedge clk); n++;
    end
    reg_wr = 1'b0;
    check(hi == 200, "R9 current period keeps old width", hi, 200);
    meas_check(2, 10, 255, "R9 new width from next period");

    // R3: out-of-range index
    wr(0, 5);
    wr(3, 16'h123); wr(1, 1); wr(2, 7);
    rd(0, v); check(v == 5, "R3 index holds 5", v, 5);
    rd(3, v); check(v == 0, "R3 read width out of range", v, 0);
    rd(2, v); check(v == 0, "R3 read divider out of range", v, 0);
    for (int c = 0; c < 4; c++) begin
      wr(0, c); rd(3, v);
      check(v != 16'h123, "R3 no channel took width", v, 0);
    end
    meas_check(0, 4 * 254, 4 * 255, "R3 ch0 output unchanged");

    // R8: full-width and zero-width levels
    cfg(3, 0, 0, 255);
    repeat (3 * 765) @(negedge clk);
    hold_check(3, 1'b1, 600, "R8 coarse full width high");
    cfg(1, 1, 0, 4095);
    repeat (2 * 4095 + 10) @(negedge clk);
    hold_check(1, 1'b1, 5000, "R8 fine full width high");
    cfg(2, 0, 0, 0);
    repeat (600) @(negedge clk);
    hold_check(2, 1'b0, 600, "R8 zero width low");

    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule